// File: doc/BRIEF.md
# Serial Register Port for a Six-Channel Gate Driver Controller

This block is the serial control port of a six-channel low-side gate driver controller. A host selects the block by pulling the active-low select low and clocks 16-bit frames in, MSB first. Each frame holds a 3-bit address, 12 data bits and one parity bit. The host must send an odd number of ones in the frame. The block checks the frame length and the parity when select is released. Only then does it act on the frame. A valid frame to one of the four write addresses updates a configuration register and raises a one-cycle write strobe.

While a frame is shifting in, the block shifts out a 16-bit reply on a serial output. The output is enabled only while select is low. The reply was built when the previous frame ended. It is an echo, a status snapshot, the revision code or an error code, and it carries its own odd parity. The serial clock, select and data inputs are sampled by the system clock through a short synchroniser. For this reason the serial clock must be much slower than the system clock.

Top module: `drv_serial_regs`

## Requirements
- R1: A frame is accepted only if the number of serial-clock rising edges while select is low is a non-zero multiple of 16. For longer frames, the last 16 bits received are decoded. Bit 15 is the first of these bits.
- R2: An accepted frame must contain an odd number of ones. A frame with even parity is discarded: no register changes and no strobe.
- R3: A discarded frame makes the next reply an error code. The code is address 111, then bits 11..1 = 01010101010, then two final bits. Those bits are 1,0 for a parity error and 0,1 for a length error. The length check takes precedence over the parity check.
- R4: A valid frame to address 000, 001 or 011 loads its 12 data bits into, in that order, the gate/mode, the diagnostic-pulse or the diagnostic-config-2 register. The next reply is an echo {address, data, parity}. One system clock after select is seen high, `wr_stb` pulses for exactly one cycle, with `wr_sel` set to the address's two low bits.
- R5: Address 010 writes config 1. Data bits 2..0 pick the channel: 000 picks none, 001..110 pick channel 0..5, and 111 picks all. For each picked channel c, the block stores the ratio code from bits 11..9 in `ratio_sel[3c+2:3c]`, the off-blank code from bits 8..7 in `blank_off[2c+1:2c]` and the on-blank code from bits 6..5 in `blank_on[2c+1:2c]`. A write that picks no channel still strobes.
- R6: Address 100 or 101 replies with a status frame. Its bits 11..10 are 00 and bit 9 is the `dis_lvl` input. Bits 8..0 take bit b of the status of the group's channel k (0..2) at position 3b+k. Address 100 covers channels 0..2, and address 101 covers channels 3..5, with channel 3 as k=0.
- R7: Address 110 replies with 110, six zeros and the 6-bit `REV_CODE`. The first reply after reset is this revision frame.
- R8: The reply sent during a frame is the one built at the end of the previous frame. Its 16 bits always contain an odd number of ones.
- R9: After reset, gate/mode = 0, pulse = 0, config 2 = 0x03F, every ratio code = 000 and every blank code = 10.
- R10: `sdo_oe` is high only while select is low. `sdo` presents the reply MSB first and advances after each serial-clock falling edge.
- R11: A valid frame to address 111 gets an echo reply. It changes no register and gives no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from host |
| csn | input | 1 | Active-low select |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the serial data pad |
| ch_status | input | 18 | 3-bit status per channel, channel c at [3c+2:3c] |
| dis_lvl | input | 1 | Global disable level, returned in status replies |
| gate_mode | output | 12 | Gate/mode register |
| pulse_sel | output | 12 | Diagnostic-pulse register |
| diag2 | output | 12 | Diagnostic-config-2 register |
| ratio_sel | output | 18 | Per-channel threshold ratio codes |
| blank_off | output | 12 | Per-channel off-state blanking codes |
| blank_on | output | 12 | Per-channel on-state blanking codes |
| wr_stb | output | 1 | One-cycle strobe after a valid write |
| wr_sel | output | 2 | Register written with the strobe |

## Verification
The length check and the parity check are decided in the same cycle, when select is released. Both can fail at once. The bench provokes this with a 15-clock and a 17-clock frame whose bit counts make the parity meaningless, and expects the length code. It also sends a 32-clock frame whose discarded first half has bad parity, and expects the second half to be written. In the same release cycle the reply for the next frame is built while the register write happens. The bench judges this by checking that the echo comes out during the following frame and that the register holds the new value.

// File: rtl/drv_serial_regs.sv
module drv_serial_regs #(
  parameter logic [5:0] REV_CODE = 6'h13,
  parameter int         SYNC_LEN = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk,
  input  logic        csn,
  input  logic        sdi,
  output logic        sdo,
  output logic        sdo_oe,
  input  logic [17:0] ch_status,
  input  logic        dis_lvl,
  output logic [11:0] gate_mode,
  output logic [11:0] pulse_sel,
  output logic [11:0] diag2,
  output logic [17:0] ratio_sel,
  output logic [11:0] blank_off,
  output logic [11:0] blank_on,
  output logic        wr_stb,
  output logic [1:0]  wr_sel
);
  localparam int NCH = 6;
  localparam int FW  = 16;
  localparam int GRP = NCH / 2;
  localparam logic [15:0] ERR_PAR = {3'b111, 11'b01010101010, 2'b10};
  localparam logic [15:0] ERR_LEN = {3'b111, 11'b01010101010, 2'b01};

  function automatic logic [FW-1:0] seal(input logic [FW-2:0] body);
    return {body, ~^body};
  endfunction

  logic [SYNC_LEN:0]   sck_p;
  logic [SYNC_LEN-1:0] cs_p, sd_p;
  logic                cs_prev;
  logic                cs_low, sck_rise, sck_fall, cs_fall, cs_rise;

  assign cs_low   = ~cs_p[SYNC_LEN-1];
  assign sck_rise = sck_p[SYNC_LEN-1] & ~sck_p[SYNC_LEN];
  assign sck_fall = ~sck_p[SYNC_LEN-1] & sck_p[SYNC_LEN];
  assign cs_fall  = cs_low & cs_prev;
  assign cs_rise  = ~cs_low & ~cs_prev;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_p   <= '0;
      cs_p    <= '1;
      sd_p    <= '0;
      cs_prev <= 1'b1;
    end else begin
      sck_p   <= {sck_p[SYNC_LEN-1:0], sclk};
      cs_p    <= {cs_p[SYNC_LEN-2:0], csn};
      sd_p    <= {sd_p[SYNC_LEN-2:0], sdi};
      cs_prev <= cs_p[SYNC_LEN-1];
    end

  logic [FW-1:0] rx_sh, tx_sh, resp;
  logic [3:0]    bit_cnt;
  logic          got_clk;
  logic [2:0]    rx_addr;
  logic [11:0]   rx_data;
  logic          frame_ok, par_ok;

  assign rx_addr  = rx_sh[15:13];
  assign rx_data  = rx_sh[12:1];
  assign frame_ok = got_clk & (bit_cnt == 4'd0);
  assign par_ok   = ^rx_sh;
  assign sdo_oe   = cs_low;
  assign sdo      = tx_sh[FW-1];

  logic [8:0] st_lo, st_hi;
  always_comb
    for (int b = 0; b < 3; b++)
      for (int k = 0; k < GRP; k++) begin
        st_lo[3*b+k] = ch_status[3*k+b];
        st_hi[3*b+k] = ch_status[3*(k+GRP)+b];
      end

  logic [FW-2:0] body;
  always_comb
    case (rx_addr)
      3'b100:  body = {3'b100, 2'b00, dis_lvl, st_lo};
      3'b101:  body = {3'b101, 2'b00, dis_lvl, st_hi};
      3'b110:  body = {3'b110, 6'b0, REV_CODE};
      default: body = {rx_addr, rx_data};
    endcase

  logic [NCH-1:0] c1_hit;
  for (genvar c = 0; c < NCH; c++) begin : g_sel
    assign c1_hit[c] = (rx_data[2:0] == 3'b111) || (rx_data[2:0] == 3'(c + 1));
  end

  logic [11:0] gate_q, pulse_q, diag2_q, boff_q, bon_q;
  logic [17:0] ratio_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_sh   <= '0;
      tx_sh   <= '0;
      bit_cnt <= '0;
      got_clk <= 1'b0;
      resp    <= seal({3'b110, 6'b0, REV_CODE});
      gate_q  <= '0;
      pulse_q <= '0;
      diag2_q <= 12'h03F;
      ratio_q <= '0;
      boff_q  <= {NCH{2'b10}};
      bon_q   <= {NCH{2'b10}};
      wr_stb  <= 1'b0;
      wr_sel  <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (cs_fall) begin
        tx_sh   <= resp;
        bit_cnt <= '0;
        got_clk <= 1'b0;
      end else if (cs_low) begin
        if (sck_rise) begin
          rx_sh   <= {rx_sh[FW-2:0], sd_p[SYNC_LEN-1]};
          bit_cnt <= bit_cnt + 4'd1;
          got_clk <= 1'b1;
        end
        if (sck_fall) tx_sh <= {tx_sh[FW-2:0], 1'b0};
      end
      if (cs_rise) begin
        if (!frame_ok)     resp <= ERR_LEN;
        else if (!par_ok)  resp <= ERR_PAR;
        else begin
          resp <= seal(body);
          if (!rx_addr[2]) begin
            wr_stb <= 1'b1;
            wr_sel <= rx_addr[1:0];
            case (rx_addr[1:0])
              2'd0: gate_q  <= rx_data;
              2'd1: pulse_q <= rx_data;
              2'd3: diag2_q <= rx_data;
              default:
                for (int c = 0; c < NCH; c++)
                  if (c1_hit[c]) begin
                    ratio_q[3*c +: 3] <= rx_data[11:9];
                    boff_q[2*c +: 2]  <= rx_data[8:7];
                    bon_q[2*c +: 2]   <= rx_data[6:5];
                  end
            endcase
          end
        end
      end
    end

  assign gate_mode = gate_q;
  assign pulse_sel = pulse_q;
  assign diag2     = diag2_q;
  assign ratio_sel = ratio_q;
  assign blank_off = boff_q;
  assign blank_on  = bon_q;
endmodule

// File: rtl/drv_serial_regs_chk.sv
module drv_serial_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sdo_oe,
  input logic        wr_stb,
  input logic [11:0] gate_mode,
  input logic [11:0] pulse_sel,
  input logic [11:0] diag2,
  input logic [17:0] ratio_sel
);
  a_r4_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  a_r4_stb_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !sdo_oe);
  a_r2_gate_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gate_mode) |-> wr_stb);
  a_r2_pulse_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pulse_sel) |-> wr_stb);
  a_r3_diag2_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(diag2) |-> wr_stb);
  a_r5_ratio_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ratio_sel) |-> wr_stb);
endmodule

bind drv_serial_regs drv_serial_regs_chk i_chk (
  .clk(clk), .rst_n(rst_n), .sdo_oe(sdo_oe), .wr_stb(wr_stb),
  .gate_mode(gate_mode), .pulse_sel(pulse_sel), .diag2(diag2),
  .ratio_sel(ratio_sel)
);

// File: tb/test_drv_serial_regs.sv
module test_drv_serial_regs;
  localparam int CLK_PERIOD = 10;
  localparam int H = 6;
  localparam logic [5:0] REV = 6'h13;

  function automatic logic [15:0] mk(input logic [2:0] a, input logic [11:0] d);
    return {a, d, ~^{a, d}};
  endfunction

  localparam logic [15:0] REVW  = mk(3'b110, {6'b0, REV});
  localparam logic [15:0] ERR_P = {3'b111, 11'b01010101010, 2'b10};
  localparam logic [15:0] ERR_F = {3'b111, 11'b01010101010, 2'b01};

  localparam int NV = 8;
  localparam logic [31:0] VEC [NV] = '{
    {mk(3'd0, 12'hA5C), REVW},
    {mk(3'd1, 12'h3C3), mk(3'd0, 12'hA5C)},
    {mk(3'd3, 12'h0F0), mk(3'd1, 12'h3C3)},
    {mk(3'd4, 12'h000), mk(3'd3, 12'h0F0)},
    {mk(3'd5, 12'h000), mk(3'd4, 12'h111)},
    {mk(3'd6, 12'h000), mk(3'd5, 12'h14D)},
    {mk(3'd7, 12'h123), REVW},
    {mk(3'd0, 12'h111), mk(3'd7, 12'h123)}
  };

  logic clk = 0, rst_n = 0, sclk = 0, csn = 1, sdi = 0, dis_lvl = 0;
  logic [17:0] ch_status = {3'b101, 3'b000, 3'b111, 3'b100, 3'b010, 3'b001};
  logic sdo, sdo_oe, wr_stb;
  logic [1:0] wr_sel;
  logic [11:0] gate_mode, pulse_sel, diag2, blank_off, blank_on;
  logic [17:0] ratio_sel;
  int nchk = 0, nerr = 0, stb_cnt = 0;
  logic [1:0] last_sel = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  drv_serial_regs #(.REV_CODE(REV)) i_drv_serial_regs (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .csn(csn), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .ch_status(ch_status), .dis_lvl(dis_lvl),
    .gate_mode(gate_mode), .pulse_sel(pulse_sel), .diag2(diag2),
    .ratio_sel(ratio_sel), .blank_off(blank_off), .blank_on(blank_on),
    .wr_stb(wr_stb), .wr_sel(wr_sel));

  always @(posedge clk) if (wr_stb) begin stb_cnt <= stb_cnt + 1; last_sel <= wr_sel; end

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] bits, input int n, input logic [15:0] exp, input string tag);
    logic [15:0] got;
    got = '0;
    @(negedge clk) csn = 0;
    repeat (H) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = bits[i];
      repeat (H) @(negedge clk);
      if (n - 1 - i < 16) got = {got[14:0], sdo};
      if (i == n - 1) chk({31'b0, sdo_oe}, 32'd1, "R10 oe while selected");
      sclk = 1;
      repeat (H) @(negedge clk);
      sclk = 0;
    end
    repeat (H) @(negedge clk);
    csn = 1;
    repeat (4 * H) @(negedge clk);
    if (n >= 16) chk({16'b0, got}, {16'b0, exp}, tag);
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired (all requirements)");
    finish_run();
  end

  initial begin
    int s0;
    do_reset();
    chk({20'b0, gate_mode}, 32'h0, "R9 gate reset");
    chk({20'b0, pulse_sel}, 32'h0, "R9 pulse reset");
    chk({20'b0, diag2}, 32'h03F, "R9 diag2 reset");
    chk({14'b0, ratio_sel}, 32'h0, "R9 ratio reset");
    chk({20'b0, blank_off}, 32'hAAA, "R9 off-blank reset");
    chk({20'b0, blank_on}, 32'hAAA, "R9 on-blank reset");
    chk({31'b0, sdo_oe}, 32'h0, "R10 oe idle");
    chk({31'b0, wr_stb}, 32'h0, "R4 no strobe at reset");

    for (int i = 0; i < NV; i++)
      xfer({16'b0, VEC[i][31:16]}, 16, VEC[i][15:0], "R4 R6 R7 R8 R11 table reply");
    chk({20'b0, gate_mode}, 32'h111, "R4 gate written");
    chk({20'b0, pulse_sel}, 32'h3C3, "R4 pulse written");
    chk({20'b0, diag2}, 32'h0F0, "R4 diag2 written");
    chk(stb_cnt, 4, "R11 strobe count excludes addr 7");
    chk({30'b0, last_sel}, 32'd0, "R4 last strobe sel");

    s0 = stb_cnt;
    xfer({16'b0, mk(3'd0, 12'h0F0) ^ 16'h1}, 16, mk(3'd0, 12'h111), "R8 echo before bad frame");
    chk({20'b0, gate_mode}, 32'h111, "R2 bad parity discarded");
    chk(stb_cnt, s0, "R2 no strobe on bad parity");
    xfer({16'b0, mk(3'd6, 12'h0)}, 16, ERR_P, "R3 parity error code");

    xfer({16'b0, mk(3'd6, 12'h0)} >> 1, 15, 16'h0, "R1 15 clocks");
    xfer({16'b0, mk(3'd6, 12'h0)}, 16, ERR_F, "R1 R3 length error after 15");
    xfer({15'b0, mk(3'd0, 12'h777), 1'b1}, 17, REVW, "R1 17 clocks");
    chk({20'b0, gate_mode}, 32'h111, "R1 17 clocks discarded");
    xfer({16'b0, mk(3'd6, 12'h0)}, 16, ERR_F, "R1 R3 length error after 17");

    xfer({mk(3'd0, 12'hFFF) ^ 16'h1, mk(3'd0, 12'h2AA)}, 32, REVW, "R1 32 clocks");
    chk({20'b0, gate_mode}, 32'h2AA, "R1 last 16 bits decoded");

    xfer({16'b0, mk(3'd2, 12'hAE3)}, 16, mk(3'd0, 12'h2AA), "R8 echo of long frame");
    chk({14'b0, ratio_sel}, 32'h140, "R5 ch2 ratio");
    chk({20'b0, blank_off}, 32'hA9A, "R5 ch2 off-blank");
    chk({20'b0, blank_on}, 32'hABA, "R5 ch2 on-blank");
    xfer({16'b0, mk(3'd2, 12'hE27)}, 16, mk(3'd2, 12'hAE3), "R5 echo cfg1");
    chk({14'b0, ratio_sel}, 32'h3FFFF, "R5 all ratio");
    chk({20'b0, blank_off}, 32'h000, "R5 all off-blank");
    chk({20'b0, blank_on}, 32'h555, "R5 all on-blank");
    s0 = stb_cnt;
    xfer({16'b0, mk(3'd2, 12'h3E0)}, 16, mk(3'd2, 12'hE27), "R5 echo all");
    chk({14'b0, ratio_sel}, 32'h3FFFF, "R5 none selected keeps ratio");
    chk({20'b0, blank_on}, 32'h555, "R5 none selected keeps on-blank");
    chk(stb_cnt, s0 + 1, "R5 none selected still strobes");
    chk({30'b0, last_sel}, 32'd2, "R4 sel for cfg1");
    xfer({16'b0, mk(3'd2, 12'h546)}, 16, mk(3'd2, 12'h3E0), "R5 echo none");
    chk({14'b0, ratio_sel}, 32'h17FFF, "R5 ch5 ratio");
    chk({20'b0, blank_off}, 32'h800, "R5 ch5 off-blank");
    chk({20'b0, blank_on}, 32'h955, "R5 ch5 on-blank");

    dis_lvl = 1;
    xfer({16'b0, mk(3'd4, 12'h0)}, 16, mk(3'd2, 12'h546), "R8 echo ch5");
    xfer({16'b0, mk(3'd6, 12'h0)}, 16, mk(3'd4, 12'h311), "R6 disable bit in status");
    dis_lvl = 0;

    do_reset();
    chk({20'b0, gate_mode}, 32'h0, "R9 gate after second reset");
    chk({20'b0, diag2}, 32'h03F, "R9 diag2 after second reset");
    chk({31'b0, sdo_oe}, 32'h0, "R10 oe idle after reset");
    xfer({16'b0, mk(3'd6, 12'h0)}, 16, REVW, "R7 first reply is revision");
    xfer({16'b0, mk(3'd5, 12'h0)}, 16, REVW, "R7 revision reply");
    xfer({16'b0, mk(3'd0, 12'h0)}, 16, mk(3'd5, 12'h14D), "R6 status ch5..3");
    finish_run();
  end
endmodule